// File: doc/BRIEF.md
# PLL Lock Event Interrupt Controller

This block watches the lock indicators of three phase-locked loops (main, peripheral and memory) and turns each change of lock into a sticky event that software can inspect, mask and clear. Each loop has two separate events. One records that the loop has gained lock and the other records that it has dropped out of lock. Both events feed a single level-sensitive interrupt line.

The raw lock indicators are asynchronous to the register clock. Each one passes through a short flop chain before an edge detector turns it into a one-cycle pulse. The pulse sets the matching sticky bit. Software reaches the block through a simple word-addressed register port. A write completes in one cycle and read data is a combinational function of the address. Enables are changed only through separate set and clear masks, so two agents can change different enables without a read-modify-write race. Status bits are cleared by writing a mask of ones.

Top module: `pll_lock_irq_ctrl`

## Requirements
- R1: Register map by word address: 0 reads the event status and a write there clears status; 1 reads the enable mask; 2 is write-only enable-set; 3 is write-only enable-clear; 4 reads the live lock state in bits 2:0 (bit0 main, bit1 peripheral, bit2 memory). Addresses 2, 3 and any unmapped address read as zero. Event status bits: bit0 main gained, bit1 peripheral gained, bit2 memory gained, bit3 main lost, bit4 peripheral lost, bit5 memory lost. Enable bit n gates status bit n.
- R2: A low-to-high change of a synchronised lock input sets that loop's gained bit. The bit stays set until software clears it.
- R3: A high-to-low change of a synchronised lock input sets that loop's lost bit. The bit stays set until software clears it.
- R4: `irq_o` is high exactly when at least one status bit and its enable bit are both set. It is low whenever the enable mask is zero.
- R5: A write to the enable-set address sets each enable bit whose mask bit is 1. Enable bits whose mask bit is 0 keep their value.
- R6: A write to the enable-clear address clears each enable bit whose mask bit is 1. Enable bits whose mask bit is 0 keep their value.
- R7: A write to the status address clears only the status bits whose mask bit is 1.
- R8: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: The live lock field follows each input after two register-clock edges and is not sticky. The matching event bit is set at the third edge after the input changes.
- R10: After reset, all status bits, all enable bits and the live lock field read as 0, and `irq_o` is low.
- R11: Write-data bits above bit 5 have no effect on the status, enable-set or enable-clear registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 3 | Raw lock indicators, asynchronous (bit0 main, bit1 peripheral, bit2 memory) |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data / mask |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a loop's lock input holds each level for at least three register-clock cycles, so that every level the synchroniser passes produces its own edge. They also assume that reset is asserted from time zero. The sweep drives every pair of lock patterns and holds each one for four cycles before sampling. It changes the inputs only at the falling clock edge, so no value is ever caught in mid-transition. A directed test places a status clear exactly on the cycle in which a pending event lands, to check that the event wins.

// File: rtl/pll_irq_pkg.sv
package pll_irq_pkg;
    // Word addresses of the register port
    localparam int unsigned ADDR_STAT   = 0;
    localparam int unsigned ADDR_EN     = 1;
    localparam int unsigned ADDR_EN_SET = 2;
    localparam int unsigned ADDR_EN_CLR = 3;
    localparam int unsigned ADDR_LIVE   = 4;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int unsigned NUM_PLL    = 3,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PLL-1:0] lock_raw,
    output logic [NUM_PLL-1:0] live,
    output logic [NUM_PLL-1:0] rise,
    output logic [NUM_PLL-1:0] fall
);
    typedef struct packed {
        logic [SYNC_DEPTH-1:0][NUM_PLL-1:0] stage;
        logic [NUM_PLL-1:0]                 prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = lock_raw;
        for (int k = 1; k < SYNC_DEPTH; k++) begin
            s_d.stage[k] = s_q.stage[k-1];
        end
        s_d.prev = s_q.stage[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign live = s_q.stage[SYNC_DEPTH-1];
    assign rise = live & ~s_q.prev;
    assign fall = ~live & s_q.prev;

    generate
        for (genvar p = 0; p < NUM_PLL; p++) begin : g_chk
            // R2
            rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise[p] |=> !rise[p]);
            // R3
            fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fall[p] |=> !fall[p]);
        end
    endgenerate
endmodule

// File: rtl/pll_evt_status.sv
module pll_evt_status #(
    parameter int unsigned NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_evt,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] status
);
    typedef struct packed {
        logic [NUM_EVT-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event overrides a clear of the same bit
        st_d.bits = (st_q.bits & ~clr_mask) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;

    generate
        for (genvar b = 0; b < NUM_EVT; b++) begin : g_chk
            // R7
            stat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(status[b]) |-> $past(clr_mask[b]));
            // R8
            evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_evt[b] |=> status[b]);
        end
    endgenerate
endmodule

// File: rtl/pll_irq_mask.sv
module pll_irq_mask #(
    parameter int unsigned NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_mask,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] enable
);
    typedef struct packed {
        logic [NUM_EVT-1:0] en;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        m_d.en = (m_q.en | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign enable = m_q.en;

    generate
        for (genvar b = 0; b < NUM_EVT; b++) begin : g_chk
            // R5
            en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(enable[b]) |-> $past(set_mask[b]));
            // R6
            en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(enable[b]) |-> $past(clr_mask[b]));
        end
    endgenerate
endmodule

// File: rtl/pll_lock_irq_ctrl.sv
module pll_lock_irq_ctrl #(
    parameter int unsigned NUM_PLL    = 3,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned DATA_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PLL-1:0] pll_lock_i,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);
    import pll_irq_pkg::*;

    localparam int unsigned EVT_W = 2 * NUM_PLL;

    logic [NUM_PLL-1:0] live, rise, fall;
    logic [EVT_W-1:0]   status, enable;
    logic [EVT_W-1:0]   stat_clr_d, en_set_d, en_clr_d;
    logic [EVT_W-1:0]   wmask;
    logic               unused_wdata_hi;

    pll_lock_sync #(.NUM_PLL(NUM_PLL), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .lock_raw(pll_lock_i),
        .live(live), .rise(rise), .fall(fall)
    );

    pll_evt_status #(.NUM_EVT(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_evt({fall, rise}),
        .clr_mask(stat_clr_d), .status(status)
    );

    pll_irq_mask #(.NUM_EVT(EVT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_mask(en_set_d),
        .clr_mask(en_clr_d), .enable(enable)
    );

    // upper write-data bits are not part of any mask
    assign wmask           = reg_wdata[EVT_W-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EVT_W];

    always_comb begin
        stat_clr_d = '0;
        en_set_d   = '0;
        en_clr_d   = '0;
        if (reg_wr_en) begin
            if (reg_addr == ADDR_W'(ADDR_STAT))   stat_clr_d = wmask;
            if (reg_addr == ADDR_W'(ADDR_EN_SET)) en_set_d   = wmask;
            if (reg_addr == ADDR_W'(ADDR_EN_CLR)) en_clr_d   = wmask;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_STAT))      reg_rdata[EVT_W-1:0]   = status;
        else if (reg_addr == ADDR_W'(ADDR_EN))   reg_rdata[EVT_W-1:0]   = enable;
        else if (reg_addr == ADDR_W'(ADDR_LIVE)) reg_rdata[NUM_PLL-1:0] = live;
    end

    assign irq_o = |(status & enable);

    // R4
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_o);

    generate
        for (genvar p = 0; p < NUM_PLL; p++) begin : g_chk
            // R2
            gain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(live[p]) |=> status[p]);
            // R3
            loss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(live[p]) |=> status[NUM_PLL+p]);
        end
    endgenerate
endmodule

// File: tb/pll_lock_irq_ctrl_test.sv
module pll_lock_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pll_lock_i = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pll_lock_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        logic [5:0]  exp_st, exp_en;

        wait_cyc(3);
        rst_n = 1'b1;
        // R10 reset state
        rd(3'd0, d); check("R10 status", d, 0);
        rd(3'd1, d); check("R10 enable", d, 0);
        rd(3'd4, d); check("R10 live", d, 0);
        check("R10 irq", {31'd0, irq_o}, 0);
        // R1 write-only and unmapped addresses read zero
        wr(3'd2, 32'h3F);
        rd(3'd2, d); check("R1 set addr reads 0", d, 0);
        rd(3'd3, d); check("R1 clr addr reads 0", d, 0);
        rd(3'd7, d); check("R1 unmapped reads 0", d, 0);
        rd(3'd1, d); check("R5 set all", d, 32'h3F);
        wr(3'd3, 32'h3F);

        // R9 latency and non-sticky live state
        pll_lock_i = 3'b001;
        @(negedge clk);
        rd(3'd4, d); check("R9 live after one edge", d, 0);
        @(negedge clk);
        rd(3'd4, d); check("R9 live after two edges", d, 1);
        rd(3'd0, d); check("R9 status not yet", d, 0);
        @(negedge clk);
        rd(3'd0, d); check("R9 R2 gained at third edge", d, 32'h01);
        pll_lock_i = 3'b000;
        wait_cyc(3);
        rd(3'd4, d); check("R9 live not sticky", d, 0);
        rd(3'd0, d); check("R3 lost main", d, 32'h09);
        check("R4 irq masked", {31'd0, irq_o}, 0);

        // R7 partial clear and R11 upper bits ignored
        pll_lock_i = 3'b111; wait_cyc(4);
        pll_lock_i = 3'b000; wait_cyc(4);
        rd(3'd0, d); check("R2 R3 all events", d, 32'h3F);
        wr(3'd0, 32'h0000_0005);
        rd(3'd0, d); check("R7 partial clear", d, 32'h3A);
        wr(3'd0, 32'hFFFF_FFC0);
        rd(3'd0, d); check("R11 status clear upper bits", d, 32'h3A);
        wr(3'd2, 32'hFFFF_FFC0);
        rd(3'd1, d); check("R11 enable set upper bits", d, 0);
        wr(3'd2, 32'h0000_0012);
        rd(3'd1, d); check("R5 set mask", d, 32'h12);
        check("R4 irq on", {31'd0, irq_o}, 1);
        wr(3'd2, 32'h0000_0001);
        rd(3'd1, d); check("R5 zeros keep", d, 32'h13);
        wr(3'd3, 32'hFFFF_FFC2);
        rd(3'd1, d); check("R6 R11 clear mask", d, 32'h11);
        wr(3'd3, 32'h11);
        rd(3'd1, d); check("R6 clear all", d, 0);
        check("R4 irq off", {31'd0, irq_o}, 0);

        // R8 event lands in the same cycle as its clear
        wr(3'd0, 32'h3F);
        pll_lock_i = 3'b010; wait_cyc(4);
        pll_lock_i = 3'b000; wait_cyc(4);
        pll_lock_i = 3'b001;
        wait_cyc(2);
        wr(3'd0, 32'h3F);
        rd(3'd0, d); check("R8 event wins over clear", d, 32'h01);

        // R1-encoded sweep over all pattern pairs
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                pll_lock_i = 3'(a);
                wait_cyc(4);
                wr(3'd0, 32'h3F);
                exp_en = 6'(((a * 8 + b) * 37) & 63);
                wr(3'd3, 32'h3F);
                wr(3'd2, {26'd0, exp_en});
                pll_lock_i = 3'(b);
                wait_cyc(4);
                exp_st = {3'(a & ~b), 3'(b & ~a)};
                rd(3'd0, d); check("R1 R2 R3 sweep status", d, {26'd0, exp_st});
                rd(3'd4, d); check("R9 sweep live", d, 32'(b));
                rd(3'd1, d); check("R5 R6 sweep enable", d, {26'd0, exp_en});
                check("R4 sweep irq", {31'd0, irq_o}, {31'd0, |(exp_st & exp_en)});
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule